// File: doc/BRIEF.md
# Two-Read One-Write Integer Register File with Write Bypass

This block holds the integer registers of a processor core. It serves two independent combinational read ports and one clocked write port. Each read port takes a register index and returns the value of that register. The write port stores data into the indexed register on the rising clock edge when its enable is high. Index zero is a constant: it reads as all zeros, and writes aimed at it are dropped.

Reads are write-first. When a read port names the register that is being written in the same cycle, it returns the incoming write data instead of the old contents. A dependent instruction can therefore read a result in the same cycle that the result is retired. The bypass does not apply to index zero.

An active-low reset clears the whole array asynchronously. While reset is low, the write port is ignored and both read ports return zero. Reset release is expected to be synchronous to the clock.

Top module: `regfile_2r1w`

## Requirements
- R1: A read port whose index is 0 returns all zeros. This holds in every cycle, including a cycle in which the write port targets index 0 with the enable high.
- R2: A write with the enable high and index 0 changes no register. Index 0 still reads zero in the following cycles.
- R3: While rst_ni is low, both read ports return zero and the write port has no effect. After rst_ni returns high, every index reads zero until it is written.
- R4: With the enable high and a nonzero write index, the register takes the write data at the rising clock edge. A later read of that index returns the data as long as no other write to it has occurred.
- R5: With the enable high and a nonzero write index, a read port whose index equals the write index returns the write data combinationally in the same cycle.
- R6: During a write, a read port whose index differs from the write index returns the value stored in its own register.
- R7: With the enable low, the write index and write data are ignored. No register changes, so a read port held on one index keeps returning the same value across the clock edge.
- R8: The two read ports decode their indices independently. In the same cycle each returns the contents of its own register, whether the indices are the same or different.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes occur on the rising edge |
| rst_ni | input | 1 | Active-low reset, asynchronous assertion |
| rd_a_addr_i | input | REG_WIDTH | Register index for read port A |
| rd_a_data_o | output | XLEN | Read port A data (combinational) |
| rd_b_addr_i | input | REG_WIDTH | Register index for read port B |
| rd_b_data_o | output | XLEN | Read port B data (combinational) |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | REG_WIDTH | Register index for the write |
| wr_data_i | input | XLEN | Data to write |

## Verification
Read data and the bypass respond with zero cycles of latency. The bench drives inputs just after a falling edge and samples both read ports a few nanoseconds later, before the next rising edge. At that point it compares them with a reference model that includes the bypass term. A write becomes visible through the stored path one cycle later. The model commits the write only after the rising edge, so the next sample checks the stored value. Reset takes effect without a clock, so the bench samples during the low phase of rst_ni and again after it is released.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  // source chosen by a read port
  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_BYPASS = 2'd1,
    RD_STORED = 2'd2
  } rd_src_e;

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned REG_WIDTH = 5,
  localparam int unsigned NumRegs  = 2 ** REG_WIDTH
) (
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [REG_WIDTH-1:0] wr_addr_i,
  output logic                 wr_live_o,
  output logic [NumRegs-1:1]   wr_stb_o
);

  // writes during reset, and writes to index 0, are dropped
  assign wr_live_o = wr_en_i && rst_ni && (wr_addr_i != '0);

  for (genvar g = 1; g < NumRegs; g++) begin : g_stb
    assign wr_stb_o[g] = wr_live_o && (wr_addr_i == REG_WIDTH'(g));
  end

endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned REG_WIDTH = 5,
  localparam int unsigned NumRegs  = 2 ** REG_WIDTH
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NumRegs-1:1]              wr_stb_i,
  input  logic [XLEN-1:0]                 wr_data_i,
  output logic [NumRegs-1:0][XLEN-1:0]    regs_o
);

  for (genvar g = 0; g < NumRegs; g++) begin : g_reg
    if (g == 0) begin : g_hardwired
      assign regs_o[g] = '0;
    end else begin : g_flop
      logic [XLEN-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          q <= '0;
        else if (wr_stb_i[g]) q <= wr_data_i;
      end
      assign regs_o[g] = q;
    end
  end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import regfile_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned REG_WIDTH = 5,
  localparam int unsigned NumRegs  = 2 ** REG_WIDTH
) (
  input  logic [REG_WIDTH-1:0]         rd_addr_i,
  input  logic [NumRegs-1:0][XLEN-1:0] regs_i,
  input  logic                         wr_live_i,
  input  logic [REG_WIDTH-1:0]         wr_addr_i,
  input  logic [XLEN-1:0]              wr_data_i,
  output logic [XLEN-1:0]              rd_data_o
);

  rd_src_e src;

  always_comb begin
    if (rd_addr_i == '0)                          src = RD_ZERO;
    else if (wr_live_i && wr_addr_i == rd_addr_i) src = RD_BYPASS;
    else                                           src = RD_STORED;
  end

  always_comb begin
    unique case (src)
      RD_ZERO:   rd_data_o = '0;
      RD_BYPASS: rd_data_o = wr_data_i;
      default:   rd_data_o = regs_i[rd_addr_i];
    endcase
  end

endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned REG_WIDTH = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [REG_WIDTH-1:0] rd_a_addr_i,
  output logic [XLEN-1:0]      rd_a_data_o,
  input  logic [REG_WIDTH-1:0] rd_b_addr_i,
  output logic [XLEN-1:0]      rd_b_data_o,
  input  logic                 wr_en_i,
  input  logic [REG_WIDTH-1:0] wr_addr_i,
  input  logic [XLEN-1:0]      wr_data_i
);

  localparam int unsigned NumRegs = 2 ** REG_WIDTH;
  localparam int unsigned NumRd   = 2;

  logic                         wr_live;
  logic [NumRegs-1:1]           wr_stb;
  logic [NumRegs-1:0][XLEN-1:0] regs;
  logic [NumRd-1:0][REG_WIDTH-1:0] rd_addr;
  logic [NumRd-1:0][XLEN-1:0]      rd_data;

  rf_wr_decode #(.REG_WIDTH(REG_WIDTH)) u_dec (
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_live_o (wr_live),
    .wr_stb_o  (wr_stb)
  );

  rf_store #(.XLEN(XLEN), .REG_WIDTH(REG_WIDTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_stb_i  (wr_stb),
    .wr_data_i (wr_data_i),
    .regs_o    (regs)
  );

  assign rd_addr[0] = rd_a_addr_i;
  assign rd_addr[1] = rd_b_addr_i;

  for (genvar p = 0; p < NumRd; p++) begin : g_rd
    rf_read_port #(.XLEN(XLEN), .REG_WIDTH(REG_WIDTH)) u_port (
      .rd_addr_i (rd_addr[p]),
      .regs_i    (regs),
      .wr_live_i (wr_live),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .rd_data_o (rd_data[p])
    );
  end

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

endmodule

// File: rtl/regfile_2r1w_chk.sv
module regfile_2r1w_chk #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned REG_WIDTH = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [REG_WIDTH-1:0] rd_a_addr_i,
  input logic [XLEN-1:0]      rd_a_data_o,
  input logic [REG_WIDTH-1:0] rd_b_addr_i,
  input logic [XLEN-1:0]      rd_b_data_o,
  input logic                 wr_en_i,
  input logic [REG_WIDTH-1:0] wr_addr_i,
  input logic [XLEN-1:0]      wr_data_i
);

  // R1
  idx0_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_a_addr_i == '0) |-> (rd_a_data_o == '0)) and
    ((rd_b_addr_i == '0) |-> (rd_b_data_o == '0)));

  // R3
  reset_reads_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (rd_a_data_o == '0 && rd_b_data_o == '0));

  // R5
  bypass_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0 && rd_a_addr_i == wr_addr_i) |-> (rd_a_data_o == wr_data_i));

  // R5
  bypass_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0 && rd_b_addr_i == wr_addr_i) |-> (rd_b_data_o == wr_data_i));

  // R4
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0 && rd_a_addr_i == wr_addr_i) |=>
      (rd_a_addr_i != $past(rd_a_addr_i) || wr_en_i || rd_a_data_o == $past(wr_data_i)));

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=>
      (rd_b_addr_i != $past(rd_b_addr_i) ||
       (wr_en_i && wr_addr_i == rd_b_addr_i) ||
       rd_b_data_o == $past(rd_b_data_o)));

endmodule

bind regfile_2r1w regfile_2r1w_chk #(.XLEN(XLEN), .REG_WIDTH(REG_WIDTH)) u_chk (.*);

// File: tb/tb_regfile_2r1w.sv
`timescale 1ns/1ps
module tb_regfile_2r1w;
  localparam int XLEN = 32;
  localparam int RW   = 5;
  localparam int NREG = 2 ** RW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [RW-1:0] rd_a_addr_i = '0, rd_b_addr_i = '0, wr_addr_i = '0;
  logic [XLEN-1:0] rd_a_data_o, rd_b_data_o, wr_data_i = '0;
  logic wr_en_i = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [XLEN-1:0] model [NREG];

  always #4 clk_i = ~clk_i;

  regfile_2r1w #(.XLEN(XLEN), .REG_WIDTH(RW)) dut (.*);

  function automatic logic [XLEN-1:0] expect_rd(input int a, input bit rst, input bit we,
                                                 input int wa, input logic [XLEN-1:0] wd);
    if (!rst || a == 0) return '0;
    if (we && wa == a && wa != 0) return wd;
    return model[a];
  endfunction

  task automatic check(input string tag, input string port, input logic [XLEN-1:0] got,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s port %s: actual=%h expected=%h", tag, port, got, exp);
    end
  endtask

  // drive after a falling edge, sample before the rising edge, commit model after it
  task automatic cyc(input string tag, input bit rst, input int ra, input int rb,
                     input bit we, input int wa, input logic [XLEN-1:0] wd);
    @(negedge clk_i);
    rst_ni = rst; rd_a_addr_i = RW'(ra); rd_b_addr_i = RW'(rb);
    wr_en_i = we; wr_addr_i = RW'(wa); wr_data_i = wd;
    #2;
    check(tag, "A", rd_a_data_o, expect_rd(ra, rst, we, wa, wd));
    check(tag, "B", rd_b_data_o, expect_rd(rb, rst, we, wa, wd));
    @(posedge clk_i);
    if (!rst) foreach (model[i]) model[i] = '0;
    else if (we && wa != 0) model[wa] = wd;
  endtask

  function automatic logic [XLEN-1:0] pat(input int i);
    return (XLEN'(i) * 32'h0101_0101) ^ 32'hA5C3_0000;
  endfunction

  initial begin
    foreach (model[i]) model[i] = '0;
    // R3: reset holds reads at zero and blocks writes
    cyc("R3", 0, 5, 0, 1, 5, 32'hDEAD_BEEF);
    cyc("R3", 0, 5, 6, 1, 6, 32'hCAFE_F00D);
    cyc("R3", 1, 5, 6, 0, 0, 32'h0);
    // R5/R6: fill with distinct values, A sees bypass, B sees previous register
    for (int i = 1; i < NREG; i++) cyc("R5", 1, i, i - 1, 1, i, pat(i));
    // R1, R2: write to index 0 is dropped and bypass suppressed
    cyc("R1", 1, 0, 0, 1, 0, 32'hFFFF_FFFF);
    cyc("R2", 1, 0, 1, 0, 0, 32'h0);
    // R4, R8: pairs read back
    for (int i = 0; i < NREG; i++) cyc("R8", 1, i, NREG - 1 - i, 0, 0, 32'h0);
    cyc("R8", 1, 9, 9, 0, 0, 32'h0);
    // R7: enable low ignores address/data
    cyc("R7", 1, 3, 4, 0, 3, 32'h1234_5678);
    cyc("R7", 1, 3, 4, 0, 4, 32'h8765_4321);
    // R6: write elsewhere while reading
    cyc("R6", 1, 10, 11, 1, 12, 32'h0BAD_CAFE);
    cyc("R4", 1, 12, 10, 0, 0, 32'h0);
    // R5: both ports on the written index
    for (int i = 1; i < NREG; i += 7) begin
      cyc("R5", 1, i, i, 1, i, ~pat(i));
      cyc("R4", 1, i, i + 1, 0, 0, 32'h0);
    end
    // R3: mid-run reset
    cyc("R3", 0, 7, 8, 1, 7, 32'h5555_AAAA);
    for (int i = 0; i < NREG; i++) cyc("R3", 1, i, (i + 1) % NREG, 0, 0, 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule